// File: doc/BRIEF.md
# Spectrum Frame Packer

This block gathers a stream of 8-bit spectral samples into output frames for a downstream packet transmitter. Samples are packed eight to a 64-bit word, with the earliest sample in the least significant byte. A frame holds only whole spectra: the largest whole number of spectra that fits the payload budget. It can therefore be shorter than the budget.

The payload is followed by two trailer words. The first is a 64-bit frame counter. The second is a 64-bit status word carrying sync, overflow and underflow flags gathered while the frame was being filled. The status word comes last because its value is only settled once the payload is complete. While the trailer goes out, the sample input is held off with a ready signal.

A mode input selects four products per channel or two products per channel. This sets the spectrum length and so the frame length. A frame opens only on a sample marked as the start of a spectrum. The mode is captured from that opening sample.

Top module: `spec_frame_packer`

## Requirements
- R1: After reset, out_valid and out_last are low, in_ready is high, and the first frame's counter word is 0.
- R2: Payload samples are packed eight per output word in arrival order, with sample k of a word in bits [8k+7:8k].
- R3: With full_stokes high a spectrum is NCHAN*4 samples, and a frame carries floor(MAX_SAMPLES/(NCHAN*4)) spectra.
- R4: With full_stokes low a spectrum is NCHAN*2 samples, and a frame carries floor(MAX_SAMPLES/(NCHAN*2)) spectra.
- R5: The word right after the last payload word is the frame counter. It starts at 0 and rises by one for each frame.
- R6: The status word follows the counter word and is the only word with out_last high. Bit 0 is sync, bit 1 is overflow, bit 2 is underflow, and all other bits are zero.
- R7: A status flag is set by a strobe in any cycle from the previous status cycle (exclusive) up to and including the counter-word cycle, in which in_ready is first low. The flags clear once the status word is loaded. A strobe in the status cycle, the second in_ready-low cycle, counts toward the next frame.
- R8: in_ready is low for exactly two consecutive cycles after each frame's last payload sample is taken, and high at all other times.
- R9: While no frame is open, valid samples with in_sos low are dropped and produce no output. A frame opens on a valid sample with in_sos high.
- R10: The mode is sampled on the frame's opening sample. A change of full_stokes later in the frame does not change that frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_stokes | input | 1 | 1: four products per channel, 0: two |
| in_valid | input | 1 | Sample present |
| in_data | input | SAMP_W | Sample value |
| in_sos | input | 1 | Sample is the first of a spectrum |
| in_ready | output | 1 | Sample accepted when high with in_valid |
| ev_sync | input | 1 | Sync event strobe |
| ev_ovf | input | 1 | Overflow event strobe |
| ev_udf | input | 1 | Underflow event strobe |
| out_valid | output | 1 | Output word present |
| out_data | output | WORD_W | Output word |
| out_last | output | 1 | Word is the frame's status word |

## Verification
The bench builds the block with NCHAN=4 and MAX_SAMPLES=40. A four-product frame is then two 16-sample spectra in four payload words. A two-product frame is five 8-sample spectra in five words. This puts both the exact-fit case and the floor arithmetic within a few dozen cycles. The bench runs a sweep of frames that alternates modes, input gaps and strobe placements, including strobes while idle, at the last payload sample and in the status cycle. Every output word is compared against values computed arithmetically from the frame index and sample position.

// File: rtl/spf_pkg.sv
package spf_pkg;
   typedef enum logic [1:0] {
      PK_IDLE = 2'd0,
      PK_PAY  = 2'd1,
      PK_CNT  = 2'd2,
      PK_STS  = 2'd3
   } pk_state_e;

   localparam int FLAG_SYNC = 0;
   localparam int FLAG_OVF  = 1;
   localparam int FLAG_UDF  = 2;
   localparam int NFLAGS    = 3;
endpackage

// File: rtl/spf_lane_packer.sv
module spf_lane_packer #(
   parameter int SAMP_W = 8,
   parameter int LANES  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      take,
   input  logic [SAMP_W-1:0]         sample,
   output logic                      word_fire,
   output logic [SAMP_W*LANES-1:0]   word
);
   localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

   logic [LW-1:0]     lane_q;
   logic [SAMP_W-1:0] hold_q [LANES];

   always_ff @(posedge clk) begin
      if (!rst_n) lane_q <= '0;
      else if (take) lane_q <= (lane_q == LW'(LANES-1)) ? '0 : lane_q + 1'b1;
   end

   assign word_fire = take && (lane_q == LW'(LANES-1));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) hold_q[i] <= '0;
         else if (take && lane_q == LW'(i)) hold_q[i] <= sample;
      end
      if (i == LANES-1) begin : g_top
         assign word[i*SAMP_W +: SAMP_W] = sample;
      end else begin : g_low
         assign word[i*SAMP_W +: SAMP_W] = hold_q[i];
      end
   end
endmodule

// File: rtl/spf_frame_seq.sv
module spf_frame_seq
   import spf_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int FRM_FS = 32,
   parameter int FRM_TI = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       full_stokes,
   input  logic       in_valid,
   input  logic       in_sos,
   output logic       in_ready,
   output logic       take,
   output pk_state_e  state
);
   pk_state_e         st_q;
   logic              mode_q;
   logic [CNT_W-1:0]  pl_cnt_q;
   logic              mode_now;
   logic [CNT_W-1:0]  frm_len;
   logic              last_samp;

   assign in_ready  = (st_q == PK_IDLE) || (st_q == PK_PAY);
   assign take      = in_valid && in_ready && ((st_q == PK_PAY) || in_sos);
   assign mode_now  = (st_q == PK_IDLE) ? full_stokes : mode_q;
   assign frm_len   = mode_now ? CNT_W'(FRM_FS) : CNT_W'(FRM_TI);
   assign last_samp = take && (pl_cnt_q == frm_len - 1'b1);
   assign state     = st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= PK_IDLE;
         mode_q   <= 1'b0;
         pl_cnt_q <= '0;
      end else begin
         if (take && st_q == PK_IDLE) mode_q <= full_stokes;
         if (last_samp)  pl_cnt_q <= '0;
         else if (take)  pl_cnt_q <= pl_cnt_q + 1'b1;
         case (st_q)
            PK_IDLE: if (last_samp) st_q <= PK_CNT;
                     else if (take) st_q <= PK_PAY;
            PK_PAY:  if (last_samp) st_q <= PK_CNT;
            PK_CNT:  st_q <= PK_STS;
            default: st_q <= PK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spf_trailer.sv
module spf_trailer
   import spf_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sts_cycle,
   input  logic              ev_sync,
   input  logic              ev_ovf,
   input  logic              ev_udf,
   output logic [WORD_W-1:0] frame_cnt,
   output logic [WORD_W-1:0] status_word
);
   logic [NFLAGS-1:0] flags_q;
   logic [NFLAGS-1:0] ev_now;

   always_comb begin
      ev_now            = '0;
      ev_now[FLAG_SYNC] = ev_sync;
      ev_now[FLAG_OVF]  = ev_ovf;
      ev_now[FLAG_UDF]  = ev_udf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q   <= '0;
         frame_cnt <= '0;
      end else if (sts_cycle) begin
         flags_q   <= ev_now;
         frame_cnt <= frame_cnt + 1'b1;
      end else begin
         flags_q   <= flags_q | ev_now;
      end
   end

   if (WORD_W > NFLAGS) begin : g_pad
      assign status_word = {{(WORD_W-NFLAGS){1'b0}}, flags_q};
   end else begin : g_nopad
      assign status_word = flags_q[WORD_W-1:0];
   end
endmodule

// File: rtl/spec_frame_packer.sv
module spec_frame_packer
   import spf_pkg::*;
#(
   parameter int SAMP_W      = 8,
   parameter int WORD_W      = 64,
   parameter int NCHAN       = 2048,
   parameter int MAX_SAMPLES = 8192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_stokes,
   input  logic              in_valid,
   input  logic [SAMP_W-1:0] in_data,
   input  logic              in_sos,
   output logic              in_ready,
   input  logic              ev_sync,
   input  logic              ev_ovf,
   input  logic              ev_udf,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_last
);
   localparam int LANES   = WORD_W / SAMP_W;
   localparam int SPEC_FS = NCHAN * 4;
   localparam int SPEC_TI = NCHAN * 2;
   localparam int FRM_FS  = (MAX_SAMPLES / SPEC_FS) * SPEC_FS;
   localparam int FRM_TI  = (MAX_SAMPLES / SPEC_TI) * SPEC_TI;
   localparam int CNT_W   = $clog2(MAX_SAMPLES + 1);

   if (SAMP_W != 8) begin : g_bad_samp
      $error("spec_frame_packer: SAMP_W must be 8");
   end
   if (WORD_W % SAMP_W != 0 || LANES < 2) begin : g_bad_word
      $error("spec_frame_packer: WORD_W must hold two or more whole samples");
   end
   if (SPEC_TI % LANES != 0) begin : g_bad_chan
      $error("spec_frame_packer: spectra must fill whole output words");
   end
   if (MAX_SAMPLES < SPEC_FS) begin : g_bad_max
      $error("spec_frame_packer: payload budget below one spectrum");
   end

   logic              take;
   pk_state_e         state;
   logic              word_fire;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] frame_cnt;
   logic [WORD_W-1:0] status_word;

   spf_frame_seq #(
      .CNT_W (CNT_W),
      .FRM_FS(FRM_FS),
      .FRM_TI(FRM_TI)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .full_stokes(full_stokes),
      .in_valid   (in_valid),
      .in_sos     (in_sos),
      .in_ready   (in_ready),
      .take       (take),
      .state      (state)
   );

   spf_lane_packer #(
      .SAMP_W(SAMP_W),
      .LANES (LANES)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .sample   (in_data),
      .word_fire(word_fire),
      .word     (word)
   );

   spf_trailer #(
      .WORD_W(WORD_W)
   ) u_trl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sts_cycle  (state == PK_STS),
      .ev_sync    (ev_sync),
      .ev_ovf     (ev_ovf),
      .ev_udf     (ev_udf),
      .frame_cnt  (frame_cnt),
      .status_word(status_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= word_fire || (state == PK_CNT) || (state == PK_STS);
         out_last  <= (state == PK_STS);
         if (word_fire)              out_data <= word;
         else if (state == PK_CNT)   out_data <= frame_cnt;
         else if (state == PK_STS)   out_data <= status_word;
      end
   end
endmodule

// File: rtl/spec_frame_packer_chk.sv
module spec_frame_packer_chk #(
   parameter int WORD_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_data,
   input logic              out_last
);
   logic [WORD_W-1:0] exp_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) exp_cnt <= '0;
      else if (out_last) exp_cnt <= exp_cnt + 1'b1;
   end

   assert_last_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_status_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_data[WORD_W-1:3] == '0));

   assert_gap_after_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   assert_counter_before_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> ($past(out_valid) && $past(out_data) == exp_cnt));

   assert_payload_then_trailer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> out_valid);

   assert_hold_two_cycles_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |=> !in_ready);

   assert_hold_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !$past(in_ready)) |=> in_ready);
endmodule

bind spec_frame_packer spec_frame_packer_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_last (out_last)
);

// File: tb/spec_frame_packer_tb.sv
`timescale 1ns/1ps
module spec_frame_packer_tb;
   localparam int NCHAN = 4;
   localparam int MAXS  = 40;
   localparam int FS_B  = 32;
   localparam int TI_B  = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        full_stokes = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_sos = 1'b0;
   logic        in_ready;
   logic        ev_sync = 1'b0, ev_ovf = 1'b0, ev_udf = 1'b0;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_last;

   int tests = 0, fails = 0;
   int n_out = 0, rd = 0, lowcnt = 0, lowseen = 0;
   int cycles = 0;
   logic [63:0] exp_cnt = '0;
   logic [63:0] out_mem [512];
   logic        last_mem [512];

   always #2.5 clk = ~clk;

   spec_frame_packer #(.SAMP_W(8), .WORD_W(64), .NCHAN(NCHAN), .MAX_SAMPLES(MAXS)) u_dut (
      .clk(clk), .rst_n(rst_n), .full_stokes(full_stokes), .in_valid(in_valid),
      .in_data(in_data), .in_sos(in_sos), .in_ready(in_ready), .ev_sync(ev_sync),
      .ev_ovf(ev_ovf), .ev_udf(ev_udf), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last));

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && n_out < 512) begin
            out_mem[n_out]  = out_data;
            last_mem[n_out] = out_last;
            n_out++;
         end
         if (!in_ready) lowcnt++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++; tests++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   function automatic logic [7:0] bval(int f, int i);
      return 8'((f * 29 + i * 7 + 3) & 255);
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive one frame's samples; first sample carries in_sos.
   task automatic send(int f, int n, bit fs, bit gap, bit flip, int ev_idx,
                       logic [2:0] ev_bits, logic [2:0] tail_ev);
      int i = 0;
      bit tog = 1'b0;
      full_stokes = fs;
      while (i < n) begin
         @(negedge clk);
         {ev_udf, ev_ovf, ev_sync} = (i == ev_idx && !(gap && tog)) ? ev_bits : 3'b000;
         if (gap && tog) begin
            in_valid = 1'b0;
         end else begin
            in_valid = 1'b1;
            in_data  = bval(f, i);
            in_sos   = (i == 0);
            if (flip && i == 1) full_stokes = ~fs;
            if (in_ready) i++;
         end
         tog = ~tog;
      end
      @(negedge clk);
      in_valid = 1'b0; in_sos = 1'b0;
      {ev_udf, ev_ovf, ev_sync} = 3'b000;
      @(negedge clk);
      {ev_udf, ev_ovf, ev_sync} = tail_ev;
      @(negedge clk);
      {ev_udf, ev_ovf, ev_sync} = 3'b000;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_frame(int f, int n, logic [63:0] status, string req);
      int nw = n / 8;
      logic [63:0] e;
      chk({req, " R8 word count"}, 64'(n_out - rd), 64'(nw + 2));
      for (int w = 0; w < nw; w++) begin
         for (int k = 0; k < 8; k++) e[8*k +: 8] = bval(f, 8*w + k);
         chk({req, " R2 payload word"}, out_mem[rd+w], e);
         chk({req, " R6 no last on payload"}, 64'(last_mem[rd+w]), 64'd0);
      end
      chk({req, " R5 counter word"}, out_mem[rd+nw], exp_cnt);
      chk({req, " R6 no last on counter"}, 64'(last_mem[rd+nw]), 64'd0);
      chk({req, " R6/R7 status word"}, out_mem[rd+nw+1], status);
      chk({req, " R6 last on status"}, 64'(last_mem[rd+nw+1]), 64'd1);
      chk({req, " R8 ready low cycles"}, 64'(lowcnt - lowseen), 64'd2);
      lowseen = lowcnt;
      rd = n_out;
      exp_cnt++;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 out_valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
      chk("R1 out_last after reset", 64'(out_last), 64'd0);
      chk("R1 in_ready after reset", 64'(in_ready), 64'd1);

      // R3: four-product frames, two spectra of 16 samples
      send(0, FS_B, 1, 0, 0, -1, 3'b000, 3'b000);
      check_frame(0, FS_B, 64'd0, "R1 R3 first frame");
      send(1, FS_B, 1, 1, 0, 5, 3'b010, 3'b000);
      check_frame(1, FS_B, 64'd2, "R3 R7 gaps+overflow");

      // R4: two-product frames, five spectra of 8 samples
      send(2, TI_B, 0, 0, 0, 0, 3'b001, 3'b000);
      check_frame(2, TI_B, 64'd1, "R4 sync at first sample");
      send(3, TI_B, 0, 1, 0, TI_B-1, 3'b100, 3'b000);
      check_frame(3, TI_B, 64'd4, "R4 R7 underflow at last sample");

      // R9: samples without start marker dropped while idle; idle event kept (R7)
      for (int j = 0; j < 6; j++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sos = 1'b0; in_data = 8'hA5;
         ev_sync  = (j == 2);
      end
      @(negedge clk);
      in_valid = 1'b0; ev_sync = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 no output from unmarked samples", 64'(n_out - rd), 64'd0);
      send(4, TI_B, 0, 0, 0, -1, 3'b000, 3'b000);
      check_frame(4, TI_B, 64'd1, "R9 R7 frame after dropped samples");

      // R10: mode flips after opening sample
      send(5, FS_B, 1, 0, 1, -1, 3'b000, 3'b000);
      check_frame(5, FS_B, 64'd0, "R10 flip to two-product");
      send(6, TI_B, 0, 1, 1, -1, 3'b000, 3'b000);
      check_frame(6, TI_B, 64'd0, "R10 flip to four-product");

      // R7: strobe in status cycle belongs to next frame
      send(7, FS_B, 1, 0, 0, 3, 3'b001, 3'b100);
      check_frame(7, FS_B, 64'd1, "R7 status-cycle strobe excluded");
      send(8, TI_B, 0, 0, 0, -1, 3'b000, 3'b000);
      check_frame(8, TI_B, 64'd4, "R7 status-cycle strobe carried");

      // Sweep over modes, gaps and strobe positions
      for (int f = 9; f < 21; f++) begin
         bit fs = f[0];
         bit gp = f[1];
         int n  = fs ? FS_B : TI_B;
         logic [2:0] eb = 3'(f % 8);
         send(f, n, fs, gp, 0, (f * 3) % n, eb, 3'b000);
         check_frame(f, n, 64'(eb), fs ? "R3 R5 sweep" : "R4 R5 sweep");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule